// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the low two address bits for a four-beat burst. When either start strobe is high at a rising clock edge, it captures the external address. The upper bits go into a holding register, and the two low bits become the starting offset. The beat count is cleared to zero at the same edge.

After the start, each rising edge with the active-low advance input low moves the beat count forward by one, modulo four. A static order input selects one of two sequences, both measured from the starting offset:
- A wrapping linear increment.
- An XOR-based interleaved order.

The outputs are the current 2-bit offset and the full burst address, which is the held upper bits joined with that offset. The order input is meant to stay fixed while a burst is running.

Top module: `burst_addr_counter`

## Requirements
- R1: While reset is active (low), and after it, until the first start, `burstOffset` and `burstAddr` are zero.
- R2: A start from either `startProc` or `startCtrl` at a rising edge makes `burstOffset` equal to `addrIn[1:0]` after that edge, with the beat count at zero.
- R3: The upper address bits `burstAddr[ADDR_W-1:2]` take `addrIn[ADDR_W-1:2]` at a start edge and do not change at any other edge.
- R4: At an edge with no start and `advanceN` high, `burstOffset` does not change.
- R5: With `orderSel` = 0 (linear), the offset is (start + beatCount) mod 4, so a burst from 2 runs 2, 3, 0, 1.
- R6: With `orderSel` = 1 (interleaved), the offset is start XOR beatCount, so a burst from 1 runs 1, 0, 3, 2.
- R7: An advance after the fourth beat wraps the sequence back to the starting offset instead of stopping.
- R8: A start during a burst reloads the offset from `addrIn[1:0]` and restarts the beat count at zero. A start takes priority over an advance at the same edge.
- R9: `burstAddr` always equals the held upper bits concatenated with `burstOffset`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Synchronous active-low reset |
| startProc | input | 1 | First start strobe, active high |
| startCtrl | input | 1 | Second start strobe, active high |
| advanceN | input | 1 | Advance the beat when low |
| orderSel | input | 1 | 0 selects linear, 1 selects interleaved |
| addrIn | input | ADDR_W | External address loaded at a start |
| burstOffset | output | 2 | Current low-order burst offset |
| burstAddr | output | ADDR_W | Held upper bits with the current offset |

## Verification
Directed bursts from every starting offset in both orders, observed over five advances, separate the linear and interleaved sequences. They also show whether the counter wraps or stops after the fourth beat. Pauses with `advanceN` high in the middle of a burst show that the offset holds. A start with the advance also low, issued mid-burst on each strobe in turn, shows the reload priority. Long random runs with a mixed strobe and advance density check the upper bits and the combined address against a bench model.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
  localparam int OFS_W = 2;

  typedef struct packed {
    logic load;  // capture address, clear beat count
    logic step;  // advance beat count
  } ctrlStrobes_t;

  typedef enum logic {
    ORDER_LINEAR     = 1'b0,
    ORDER_INTERLEAVE = 1'b1
  } burstOrder_e;
endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_addr_pkg::*;
(
  input  logic         startProc,
  input  logic         startCtrl,
  input  logic         advanceN,
  output ctrlStrobes_t strobes
);
  always_comb begin
    strobes.load = startProc | startCtrl;
    // a start wins over an advance in the same cycle
    strobes.step = ~strobes.load & ~advanceN;
  end
endmodule

// File: rtl/burst_datapath.sv
module burst_datapath
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic              orderSel,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [OFS_W-1:0]  burstOffset,
  output logic [ADDR_W-1:0] burstAddr
);
  localparam int UPPER_W = ADDR_W - OFS_W;

  logic [UPPER_W-1:0] upperReg;
  logic [OFS_W-1:0]   startOfs;
  logic [OFS_W-1:0]   beatCount;
  burstOrder_e        order;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      upperReg  <= '0;
      startOfs  <= '0;
      beatCount <= '0;
    end else if (strobes.load) begin
      upperReg  <= addrIn[ADDR_W-1:OFS_W];
      startOfs  <= addrIn[OFS_W-1:0];
      beatCount <= '0;
    end else if (strobes.step) begin
      beatCount <= beatCount + 1'b1;
    end
  end

  always_comb begin
    order = burstOrder_e'(orderSel);
    unique case (order)
      ORDER_LINEAR:     burstOffset = startOfs + beatCount;
      ORDER_INTERLEAVE: burstOffset = startOfs ^ beatCount;
      default:          burstOffset = startOfs;
    endcase
    burstAddr = {upperReg, burstOffset};
  end
endmodule

// File: rtl/burst_addr_counter.sv
module burst_addr_counter
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startProc,
  input  logic              startCtrl,
  input  logic              advanceN,
  input  logic              orderSel,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [1:0]        burstOffset,
  output logic [ADDR_W-1:0] burstAddr
);
  ctrlStrobes_t strobes;

  burst_ctrl u_ctrl (
    .startProc(startProc),
    .startCtrl(startCtrl),
    .advanceN (advanceN),
    .strobes  (strobes)
  );

  burst_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .orderSel   (orderSel),
    .addrIn     (addrIn),
    .burstOffset(burstOffset),
    .burstAddr  (burstAddr)
  );
endmodule

// File: rtl/burst_addr_checker.sv
module burst_addr_checker #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rstN,
  input logic              startProc,
  input logic              startCtrl,
  input logic              advanceN,
  input logic              orderSel,
  input logic [ADDR_W-1:0] addrIn,
  input logic [1:0]        burstOffset,
  input logic [ADDR_W-1:0] burstAddr
);
  logic anyStart;
  assign anyStart = startProc | startCtrl;

  always_comb begin
    if (rstN) assert_addr_join_R9: assert (burstAddr[1:0] == burstOffset);
  end

  assert_load_offset_R2: assert property (@(posedge clk) disable iff (!rstN)
    anyStart |=> burstOffset == $past(addrIn[1:0]));

  assert_upper_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    anyStart |=> burstAddr[ADDR_W-1:2] == $past(addrIn[ADDR_W-1:2]));

  assert_upper_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !anyStart |=> $stable(burstAddr[ADDR_W-1:2]));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!anyStart && advanceN && $stable(orderSel)) |=>
      (orderSel != $past(orderSel)) || burstOffset == $past(burstOffset));

  assert_linear_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!anyStart && !advanceN && !orderSel) |=>
      orderSel || burstOffset == $past(burstOffset) + 2'd1);

  assert_interleave_toggle_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!anyStart && !advanceN && orderSel) |=>
      !orderSel || burstOffset[0] != $past(burstOffset[0]));
endmodule

bind burst_addr_counter burst_addr_checker #(.ADDR_W(ADDR_W)) u_checker (
  .clk(clk), .rstN(rstN), .startProc(startProc), .startCtrl(startCtrl),
  .advanceN(advanceN), .orderSel(orderSel), .addrIn(addrIn),
  .burstOffset(burstOffset), .burstAddr(burstAddr)
);

// File: tb/burst_addr_counter_bench.sv
`timescale 1ns/1ps
module burst_addr_counter_bench;
  localparam int ADDR_W = 18;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              startProc = 1'b0;
  logic              startCtrl = 1'b0;
  logic              advanceN = 1'b1;
  logic              orderSel = 1'b0;
  logic [ADDR_W-1:0] addrIn = '0;
  logic [1:0]        burstOffset;
  logic [ADDR_W-1:0] burstAddr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [ADDR_W-3:0] mUpper = '0;
  logic [1:0]        mStart = '0;
  logic [1:0]        mCount = '0;

  always #2.5 clk = ~clk;

  burst_addr_counter #(.ADDR_W(ADDR_W)) u_burst_addr_counter (
    .clk(clk), .rstN(rstN), .startProc(startProc), .startCtrl(startCtrl),
    .advanceN(advanceN), .orderSel(orderSel), .addrIn(addrIn),
    .burstOffset(burstOffset), .burstAddr(burstAddr)
  );

  function automatic logic [1:0] expOffset(logic [1:0] s, logic [1:0] c, logic o);
    return o ? (s ^ c) : (s + c);
  endfunction

  task automatic check(string tag, logic [ADDR_W-1:0] act, logic [ADDR_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic checkModel(string tag);
    logic [1:0] eo;
    eo = expOffset(mStart, mCount, orderSel);
    check(tag, {{(ADDR_W-2){1'b0}}, burstOffset}, {{(ADDR_W-2){1'b0}}, eo});
    check("R9", burstAddr, {mUpper, eo});
  endtask

  // drive at negedge, update model at posedge, compare at next negedge
  task automatic cycle(logic sp, logic sc, logic advN, logic [ADDR_W-1:0] a);
    startProc = sp; startCtrl = sc; advanceN = advN; addrIn = a;
    @(posedge clk);
    if (sp || sc) begin
      mUpper = a[ADDR_W-1:2]; mStart = a[1:0]; mCount = 2'd0;
    end else if (!advN) begin
      mCount = mCount + 2'd1;
    end
    @(negedge clk);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [1:0] seqL [4];
    logic [1:0] seqI [4];
    void'($urandom(32'd4242));
    @(negedge clk); @(negedge clk);
    check("R1 in reset", burstAddr, '0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset", burstAddr, '0);

    // R5 linear from 2: 2,3,0,1 then R7 wrap to 2
    orderSel = 1'b0;
    seqL = '{2'd2, 2'd3, 2'd0, 2'd1};
    cycle(1, 0, 1, {16'hABCD, 2'd2});
    check("R2 proc load", {16'b0, burstOffset}, 18'd2);
    for (int i = 1; i < 4; i++) begin
      cycle(0, 0, 0, '0);
      check("R5 linear seq", {16'b0, burstOffset}, {16'b0, seqL[i]});
    end
    cycle(0, 0, 0, '0);
    check("R7 linear wrap", {16'b0, burstOffset}, 18'd2);
    check("R3 upper held", burstAddr, {16'hABCD, 2'd2});

    // R6 interleaved from 1: 1,0,3,2 with a pause (R4)
    orderSel = 1'b1;
    seqI = '{2'd1, 2'd0, 2'd3, 2'd2};
    cycle(0, 1, 1, {16'h1234, 2'd1});
    check("R2 ctrl load", {16'b0, burstOffset}, 18'd1);
    for (int i = 1; i < 4; i++) begin
      cycle(0, 0, 0, '0);
      check("R6 interleave seq", {16'b0, burstOffset}, {16'b0, seqI[i]});
      cycle(0, 0, 1, 18'h3FFFF);
      check("R4 hold", {16'b0, burstOffset}, {16'b0, seqI[i]});
    end
    cycle(0, 0, 0, '0);
    check("R7 interleave wrap", {16'b0, burstOffset}, 18'd1);

    // R8 reload mid-burst with advance low
    cycle(0, 0, 0, '0);
    cycle(1, 0, 0, {16'h0F0F, 2'd3});
    check("R8 reload priority", burstAddr, {16'h0F0F, 2'd3});
    cycle(0, 0, 0, '0);
    check("R8 count restarted", {16'b0, burstOffset}, 18'd2);
    cycle(0, 1, 0, {16'h5555, 2'd0});
    check("R8 ctrl reload", burstAddr, {16'h5555, 2'd0});

    // every start offset, both orders, five advances
    for (int o = 0; o < 2; o++) begin
      orderSel = o[0];
      for (int s = 0; s < 4; s++) begin
        cycle(1, 0, 1, {$urandom_range(0, 65535), s[1:0]});
        checkModel(o ? "R6" : "R5");
        for (int k = 0; k < 5; k++) begin
          cycle(0, 0, 0, '0);
          checkModel(k == 4 ? "R7" : (o ? "R6" : "R5"));
        end
      end
    end

    // random traffic
    for (int n = 0; n < 600; n++) begin
      logic sp, sc, advN;
      sp = ($urandom_range(0, 7) == 0);
      sc = ($urandom_range(0, 7) == 0);
      advN = ($urandom_range(0, 2) == 0);
      if ((sp || sc) && $urandom_range(0, 3) == 0) orderSel = ~orderSel;
      cycle(sp, sc, advN, 18'($urandom));
      checkModel((sp || sc) ? "R2" : (advN ? "R4" : (orderSel ? "R6" : "R5")));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule